// File: doc/BRIEF.md
# Burst Synchronous SRAM with Zero Turnaround

This block is a synthesizable model of a single-clock synchronous static RAM. It is built for designs that want every clock to carry a transfer. Address, control, byte-lane enables and write data are all registered on the rising clock edge. A read returns its word in the cycle that follows the edge that took its address, so the read path is flow-through. A write takes its data one active edge after its address (late write). Because of this, a read may directly follow a write, and a write may directly follow a read, with no idle cycle between them.

A cycle starts on an edge with `burst_next` low. That edge loads a new address and starts a read, a write or a deselect. Each later edge with `burst_next` high steps a 2-bit beat counter. The address then moves through a four-word group in one of two orders. With `order_ilv` high the order is interleaved: the low address bits are the start bits XOR the count. With `order_ilv` low the order is linear: the start bits plus the count, modulo 4. The upper address bits do not change during a burst.

While `susp` is high, every edge is ignored and all state is frozen. Three chip selects must all be active for a cycle to be a read or a write.

The control is a three-state machine. The states are CYC_IDLE (deselected), CYC_READ and CYC_WRITE. The transitions are:
- LOAD_RD: load while selected with `wr_n` high.
- LOAD_WR: load while selected with `wr_n` low.
- LOAD_DESEL: load while not selected.
- CONTINUE: an advance edge, which keeps the current state.

Reset forces CYC_IDLE.

Top module: `burst_sram`

## Requirements
- R1: After reset the block is deselected. `dout_vld` is 0, `dout` is 0, the beat counter is 0 and no write is pending. Advance edges alone do not leave the deselected state.
- R2: On an edge with `susp` high, all inputs are ignored and all state keeps its value. This includes any pending write, which then takes its data only on the next edge with `susp` low. `dout` and `dout_vld` stay unchanged.
- R3: An active edge with `burst_next` low loads `addr`, clears the beat counter and starts a new cycle.
- R4: An active edge with `burst_next` high increments the 2-bit beat counter, wrapping from 3 to 0, and keeps the cycle type.
- R5: With `order_ilv` = 1, the beat address low bits are the start low bits XOR the count.
- R6: With `order_ilv` = 0, the beat address low bits are (start low bits + count) mod 4. Address bits above bit 1 are held throughout the burst.
- R7: A write beat stores the `din` present at the next active edge. Lane i occupies bits [9i+8:9i]. Lane i is updated only if `lane_wr_n[i]` was 0 at the beat's own edge.
- R8: A cycle is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A load under any other combination is a deselect: `dout_vld` is 0, `dout` is 0 and nothing is written.
- R9: After the edge of a read beat, `dout` holds the word at that beat's address and `dout_vld` is 1 until the next active edge. In write and deselect cycles, `dout_vld` is 0 and `dout` is 0.
- R10: Reads and writes may alternate on consecutive edges with no idle cycle. A read right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| susp | input | 1 | When high, the edge is ignored and all state is frozen |
| burst_next | input | 1 | 0 = load a new address and cycle, 1 = advance the burst |
| wr_n | input | 1 | Cycle type on a load: 0 = write, 1 = read |
| lane_wr_n | input | LANES (2) | Active-low byte-lane write enables, sampled on each beat |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| order_ilv | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| addr | input | AW (6) | Word address taken on a load |
| din | input | DW (18) | Write data for the previous write beat |
| dout | output | DW (18) | Read data, flow-through |
| dout_vld | output | 1 | High while `dout` carries a read beat |

## Verification
Some properties are checked by assertions on every cycle:
- the freeze of the cycle state and of the outputs under suspend;
- the clearing, stepping and 3-to-0 wrap of the beat counter;
- the hold of the upper address bits across advance edges;
- the invalid output after a deselect load.

Other behaviour only the bench's scenarios can show:
- the data contents produced by the two burst orders;
- the late-write timing and byte-lane merging;
- the read-after-write result on consecutive edges;
- the proof that deselected or suspended edges leave memory untouched, which the bench reads back through later reads.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

    // Low two address bits of a beat, for either burst order
    function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
        return ilv ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/burst_seq.sv
module burst_seq
    import burst_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    input  logic          load,
    input  logic          ilv,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] beat_addr
);
    localparam int HI = AW - 2;

    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
        end else if (act) begin
            if (load) begin
                base_q <= addr_in;
                cnt_q  <= 2'd0;
            end else begin
                cnt_q  <= cnt_q + 2'd1;
            end
        end
    end

    assign beat_addr = {base_q[AW-1 -: HI], beat_lo(base_q[1:0], cnt_q, ilv)};

    p_load_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act && load) |=> (cnt_q == 2'd0));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !load) |=> (cnt_q == $past(cnt_q) + 2'd1));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !load && cnt_q == 2'd3) |=> (cnt_q == 2'd0));

    p_hold_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> ($stable(cnt_q) && $stable(base_q)));

endmodule

// File: rtl/cyc_ctrl.sv
module cyc_ctrl
    import burst_sram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic             load,
    input  logic             sel,
    input  logic             wr_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic             rd_on,
    output logic             wr_on,
    output logic [LANES-1:0] lane_en
);
    cyc_e state_q, state_d;

    // Next-state choice: LOAD_RD, LOAD_WR, LOAD_DESEL or CONTINUE
    always_comb begin
        state_d = state_q;
        if (load) begin
            if (!sel)      state_d = CYC_IDLE;
            else if (wr_n) state_d = CYC_READ;
            else           state_d = CYC_WRITE;
        end else begin
            unique case (state_q)
                CYC_IDLE:  state_d = CYC_IDLE;
                CYC_READ:  state_d = CYC_READ;
                CYC_WRITE: state_d = CYC_WRITE;
                default:   state_d = CYC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CYC_IDLE;
            lane_en <= '0;
        end else if (act) begin
            state_q <= state_d;
            lane_en <= ~lane_wr_n;
        end
    end

    always_comb begin
        rd_on = 1'b0;
        wr_on = 1'b0;
        unique case (state_q)
            CYC_IDLE:  ;
            CYC_READ:  rd_on = 1'b1;
            CYC_WRITE: wr_on = 1'b1;
            default:   ;
        endcase
    end

    p_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> ($stable(state_q) && $stable(lane_en)));

    p_one_type_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_on, wr_on}));

endmodule

// File: rtl/sram_bank.sv
module sram_bank #(
    parameter int AW    = 6,
    parameter int LW    = 9,
    parameter int LANES = 2
) (
    input  logic                clk,
    input  logic                we,
    input  logic [LANES-1:0]    lane_en,
    input  logic [AW-1:0]       addr,
    input  logic [LANES*LW-1:0] wdata,
    output logic [LANES*LW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_en[g]) mem[addr] <= wdata[g*LW +: LW];
        end

        assign rdata[g*LW +: LW] = mem[addr];
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LW    = 9,
    parameter int LANES = 2,
    localparam int DW   = LANES * LW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             susp,
    input  logic             burst_next,
    input  logic             wr_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             order_ilv,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    output logic             dout_vld
);
    logic             act, load, sel, rd_on, wr_on;
    logic [LANES-1:0] lane_en;
    logic [AW-1:0]    beat_addr;
    logic [DW-1:0]    rdata;

    assign act  = !susp;
    assign load = !burst_next;
    assign sel  = !sel_a_n && sel_b && !sel_c_n;

    burst_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .load      (load),
        .ilv       (order_ilv),
        .addr_in   (addr),
        .beat_addr (beat_addr)
    );

    cyc_ctrl #(.LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .load      (load),
        .sel       (sel),
        .wr_n      (wr_n),
        .lane_wr_n (lane_wr_n),
        .rd_on     (rd_on),
        .wr_on     (wr_on),
        .lane_en   (lane_en)
    );

    // Late write: the data for the current write beat arrives at the next active edge
    sram_bank #(.AW(AW), .LW(LW), .LANES(LANES)) u_bank (
        .clk     (clk),
        .we      (act && wr_on),
        .lane_en (lane_en),
        .addr    (beat_addr),
        .wdata   (din),
        .rdata   (rdata)
    );

    assign dout     = rd_on ? rdata : '0;
    assign dout_vld = rd_on;

    p_desel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act && load && !sel) |=> (!dout_vld && dout == '0));

    p_upper_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !load) |=> (beat_addr[AW-1:2] == $past(beat_addr[AW-1:2])));

    p_out_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> ($stable(dout) && $stable(dout_vld)));

    p_read_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act && load && sel && wr_n) |=> dout_vld);

endmodule

// File: tb/sim_burst_sram.sv
module sim_burst_sram;

    localparam int AW = 6;
    localparam int DW = 18;

    typedef struct packed {
        logic          susp;
        logic          ld;
        logic          wr;
        logic [1:0]    lwn;
        logic [2:0]    cs;
        logic          ilv;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          vld;
        logic [DW-1:0] exp;
        logic [3:0]    req;
    } vec_t;

    // cs = {sel_a_n, sel_b, sel_c_n}; 3'b010 selects
    localparam logic [2:0] ON = 3'b010;
    localparam int NV = 39;
    localparam vec_t TBL [NV] = '{
        '{0,1,1,2'b00,ON,1,6'h10,18'h00000,0,18'h00000,4'd7},  // R7 write burst at 0x10
        '{0,0,0,2'b00,ON,1,6'h00,18'h11111,0,18'h00000,4'd7},
        '{0,0,0,2'b00,ON,1,6'h00,18'h22222,0,18'h00000,4'd4},
        '{0,0,0,2'b00,ON,1,6'h00,18'h33333,0,18'h00000,4'd4},
        '{0,1,0,2'b00,ON,1,6'h10,18'h04444,1,18'h11111,4'd10}, // R10 read right after write
        '{0,0,0,2'b00,ON,1,6'h00,18'h00000,1,18'h22222,4'd5},  // R5
        '{0,0,0,2'b00,ON,1,6'h00,18'h00000,1,18'h33333,4'd5},
        '{0,0,0,2'b00,ON,1,6'h00,18'h00000,1,18'h04444,4'd5},
        '{0,0,0,2'b00,ON,1,6'h00,18'h00000,1,18'h11111,4'd4},  // R4 wrap
        '{0,1,0,2'b00,ON,1,6'h11,18'h00000,1,18'h22222,4'd3},  // R3
        '{0,0,0,2'b00,ON,1,6'h00,18'h00000,1,18'h11111,4'd5},  // R5 1^1
        '{0,0,0,2'b00,ON,1,6'h00,18'h00000,1,18'h04444,4'd5},  // 1^2
        '{0,0,0,2'b00,ON,1,6'h00,18'h00000,1,18'h33333,4'd5},  // 1^3
        '{0,1,0,2'b00,ON,0,6'h11,18'h00000,1,18'h22222,4'd3},  // R3
        '{0,0,0,2'b00,ON,0,6'h00,18'h00000,1,18'h33333,4'd6},  // R6 linear
        '{0,0,0,2'b00,ON,0,6'h00,18'h00000,1,18'h04444,4'd6},
        '{0,0,0,2'b00,ON,0,6'h00,18'h00000,1,18'h11111,4'd6},
        '{0,1,0,2'b00,ON,0,6'h13,18'h00000,1,18'h04444,4'd9},  // R9
        '{0,0,0,2'b00,ON,0,6'h00,18'h00000,1,18'h11111,4'd6},  // 3+1 mod 4
        '{0,1,1,2'b10,ON,0,6'h12,18'h00000,0,18'h00000,4'd7},  // lane0 only
        '{0,1,0,2'b00,ON,0,6'h12,18'h3FFFF,1,18'h333FF,4'd7},
        '{0,1,1,2'b01,ON,0,6'h12,18'h00000,0,18'h00000,4'd10}, // write right after read
        '{0,1,0,2'b00,ON,0,6'h12,18'h00000,1,18'h001FF,4'd7},  // lane1 only
        '{0,1,0,2'b00,3'b011,0,6'h10,18'h00000,0,18'h00000,4'd8}, // R8 third select off
        '{0,1,1,2'b00,3'b110,0,6'h10,18'h00000,0,18'h00000,4'd8}, // first select off
        '{0,1,0,2'b00,3'b000,0,6'h10,18'h2AAAA,0,18'h00000,4'd8}, // second select off
        '{0,1,0,2'b00,ON,0,6'h10,18'h15555,1,18'h11111,4'd8},  // memory untouched
        '{0,1,0,2'b00,ON,1,6'h13,18'h00000,1,18'h04444,4'd9},
        '{1,1,1,2'b00,ON,1,6'h10,18'h00000,1,18'h04444,4'd2},  // R2 suspended load
        '{1,0,0,2'b00,ON,1,6'h00,18'h00000,1,18'h04444,4'd2},  // suspended advance
        '{0,0,0,2'b00,ON,1,6'h00,18'h00000,1,18'h001FF,4'd2},  // resumes at beat 1
        '{0,1,1,2'b00,ON,1,6'h14,18'h00000,0,18'h00000,4'd7},
        '{1,1,0,2'b00,ON,1,6'h00,18'h15555,0,18'h00000,4'd2},
        '{1,1,0,2'b00,ON,1,6'h00,18'h2AAAA,0,18'h00000,4'd2},
        '{0,1,0,2'b00,ON,1,6'h14,18'h0ABCD,1,18'h0ABCD,4'd2},  // data taken at active edge
        '{0,1,1,2'b00,ON,1,6'h15,18'h00000,0,18'h00000,4'd10},
        '{0,1,1,2'b00,ON,1,6'h16,18'h12345,0,18'h00000,4'd10},
        '{0,1,0,2'b00,ON,1,6'h15,18'h2468A,1,18'h12345,4'd10},
        '{0,0,0,2'b00,ON,0,6'h00,18'h00000,1,18'h2468A,4'd10}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          susp = 1'b0, burst_next = 1'b1, wr_n = 1'b1;
    logic [1:0]    lane_wr_n = 2'b11;
    logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1, order_ilv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_vld;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    burst_sram u0 (
        .clk(clk), .rst_n(rst_n), .susp(susp), .burst_next(burst_next),
        .wr_n(wr_n), .lane_wr_n(lane_wr_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .order_ilv(order_ilv), .addr(addr), .din(din),
        .dout(dout), .dout_vld(dout_vld)
    );

    task automatic check(input logic ev, input logic [DW-1:0] ed, input int req, input int idx);
        checks++;
        if (dout_vld !== ev || dout !== ed) begin
            errors++;
            $display("FAIL R%0d step %0d: vld=%0b dout=%05h expected vld=%0b dout=%05h",
                     req, idx, dout_vld, dout, ev, ed);
        end
    endtask

    task automatic apply(input vec_t v);
        susp = v.susp; burst_next = !v.ld; wr_n = !v.wr; lane_wr_n = v.lwn;
        {sel_a_n, sel_b, sel_c_n} = v.cs; order_ilv = v.ilv; addr = v.a; din = v.d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1ms;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1'b0, '0, 1, -1);          // R1 reset state
        rst_n = 1'b1;
        @(negedge clk);
        apply('{0,0,0,2'b00,ON,0,6'h00,18'h0,0,18'h0,4'd1}); // R1 advance only
        check(1'b0, '0, 1, -2);
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            check(TBL[i].vld, TBL[i].exp, int'(TBL[i].req), i);
        end
        // R1: reset in the middle of a read burst
        rst_n = 1'b0;
        @(negedge clk);
        check(1'b0, '0, 1, -3);
        rst_n = 1'b1;
        @(negedge clk);
        apply('{0,0,0,2'b00,ON,0,6'h00,18'h0,0,18'h0,4'd1});
        check(1'b0, '0, 1, -4);
        apply('{0,1,0,2'b00,ON,0,6'h10,18'h0,1,18'h11111,4'd9}); // R9 read after reset
        check(1'b1, 18'h11111, 9, -5);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule